// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Command Interface

This block is the digital control side of a two-channel programmable resistor. A host shifts 24-bit command frames into it over a three-wire serial link (serial clock, data in, active-low select). The block keeps one live wiper position and one backup copy for each channel. The backup copy stands in for nonvolatile storage and is modelled as a plain register. Each frame is held until the select line is released. Only then is it decoded and acted on. The frame is discarded if the bit count is wrong, if the block is busy, or if write protection blocks the command.

The serial output always presents the frame shifted in one frame earlier, so several devices can be chained. After a read command it presents a register value instead. A level-sensitive write-protect input locks both the live and backup values, while refresh operations stay available. A preset strobe copies both backup values into the wipers. A ready flag stays low for a set number of clocks after the slow operations. All serial and strobe inputs are assumed to be synchronous to the system clock and slower than it.

Top module: `dual_wiper_serial_if`

## Requirements
- R1: After reset both wiper positions equal midscale (0x200 for 10-bit wipers), every backup copy equals midscale, ready is high and sdo is low.
- R2: While cs_n is low, each rising edge of sclk shifts sdi into the frame, most significant bit first. The frame acts only on the clock after cs_n rises. Its layout is opcode in bits 23:20, address in bits 19:16 and data in bits 15:0. Opcode 11 loads data bits 9:0 into the addressed wiper.
- R3: With no read pending, the 24 bits presented on sdo during a frame (sampled before each sclk rise) equal the previous frame, most significant bit first.
- R4: After opcode 9 (read backup) or opcode 10 (read wiper), the next frame presents the addressed value on sdo, zero-extended to 24 bits.
- R5: Address 0 selects channel 0 (wiper_pos bits 9:0) and address 1 selects channel 1 (bits 19:10). A command with any other address has no effect and leaves ready high.
- R6: Opcode 2 copies the addressed wiper into its backup. Opcode 3 writes data bits 9:0 into the addressed backup. Opcode 1 reloads the addressed wiper from its backup. Opcode 8 reloads both wipers from their backups.
- R7: While wp_n is low, opcodes 2, 3 and 11 are ignored and leave ready high. Opcodes 1 and 8 and the preset strobe still take effect.
- R8: A low-to-high transition on preset reloads both wipers from their backup copies.
- R9: Opcodes 2, 3, 8, 9 and 10, and an accepted preset, hold ready low for exactly BUSY_CYCLES clocks. All other commands leave ready high.
- R10: While ready is low, completed frames and preset strobes are ignored. Wipers, backups and the sdo contents are left as if the frame had only been shifted through.
- R11: A frame whose bit count is not exactly 24 when cs_n rises is discarded without effect.
- R12: Opcodes 0, 4 to 7 and 12 to 15 have no effect and leave ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial shift clock, sampled by clk |
| cs_n | input | 1 | Active-low frame select; rising edge triggers execution |
| sdi | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Active-low write protect |
| preset | input | 1 | Reload strobe, acts on its rising edge |
| sdo | output | 1 | Serial data out (chain or readback) |
| ready | output | 1 | High when idle; low while a slow operation runs |
| wiper_pos | output | NCH*WW | Live wiper positions, channel 0 in the low bits |

## Verification
A corrupted backup copy stays invisible until a read-backup command, a refresh or a preset brings it out. The sweeps therefore follow every store with both a readback frame and a refresh, one frame later. A wrong live wiper shows directly on wiper_pos one clock after the select rises. A bit-count or shift fault shows on sdo in the next frame, as a chained word that does not match. A busy-timer error appears as a ready pulse whose length differs from BUSY_CYCLES, or as a command that took effect inside that window.

// File: rtl/wiper_if_pkg.sv
// Package: shared frame layout and opcode values for the dual wiper interface.
// Assumes a fixed 24-bit frame: opcode, address, data from MSB to LSB.
package wiper_if_pkg;

    localparam int FRAME_W = 24;
    localparam int OP_W    = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = FRAME_W - OP_W - ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP         = 4'd0,
        OP_RESTORE_ONE = 4'd1,
        OP_SAVE_ONE    = 4'd2,
        OP_SET_BACKUP  = 4'd3,
        OP_RESTORE_ALL = 4'd8,
        OP_READ_BACKUP = 4'd9,
        OP_READ_WIPER  = 4'd10,
        OP_SET_WIPER   = 4'd11
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

endpackage

// File: rtl/wiper_serial_shifter.sv
// Module: serial front end. Detects sclk and cs_n edges in the clk domain,
// shifts sdi into a frame register and counts bits in the frame, saturating
// at the counter maximum. The same register drives sdo from its MSB, which
// gives the one-frame delay used for chaining. A parallel load replaces it
// for readback. Assumes sclk, cs_n and sdi are synchronous to clk.
module wiper_serial_shifter #(
    parameter int FRAME_W = 24,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               sdi,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_word,
    output logic [FRAME_W-1:0] frame_word,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               sclk_rise,
    output logic               cs_rise,
    output logic               sdo
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic               sclk_q;
    logic               cs_q;
    logic [FRAME_W-1:0] shreg;

    // Previous samples of the serial clock and the select, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign sclk_rise = sclk & ~sclk_q;
    assign cs_rise   = cs_n & ~cs_q;

    // Shift register: parallel load for readback, otherwise shift while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_en) begin
            shreg <= load_word;
        end else if (!cs_n && sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], sdi};
        end
    end

    // Bit counter: cleared while deselected, saturating count of shifted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (cs_n) begin
            bit_cnt <= '0;
        end else if (sclk_rise && bit_cnt != CNT_MAX) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign frame_word = shreg;
    assign sdo        = shreg[FRAME_W-1];

endmodule

// File: rtl/wiper_cmd_decoder.sv
// Module: combinational command decoder. It turns an accepted frame or an
// accepted preset strobe into per-channel update strobes, a readback request
// and a busy start. Write protection and address range are checked here.
// Assumes exec_valid and preset_go are one-cycle pulses that are already
// gated by ready; a frame in the same cycle takes priority over preset.
module wiper_cmd_decoder
    import wiper_if_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int IDX_W = 1
) (
    input  frame_t           frame,
    input  logic             exec_valid,
    input  logic             preset_go,
    input  logic             wp_n,
    output logic [NCH-1:0]   wip_set,
    output logic [NCH-1:0]   wip_restore,
    output logic [NCH-1:0]   bk_save,
    output logic [NCH-1:0]   bk_set,
    output logic             rd_req,
    output logic             rd_from_bk,
    output logic [IDX_W-1:0] rd_idx,
    output logic             start_busy
);
    localparam logic [ADDR_W-1:0] NCH_A = ADDR_W'(NCH);

    logic addr_ok;

    assign addr_ok = (frame.addr < NCH_A);
    assign rd_idx  = frame.addr[IDX_W-1:0];

    // Decode: map one accepted event to its update strobes.
    always_comb begin
        wip_set     = '0;
        wip_restore = '0;
        bk_save     = '0;
        bk_set      = '0;
        rd_req      = 1'b0;
        rd_from_bk  = 1'b0;
        start_busy  = 1'b0;
        if (exec_valid) begin
            case (frame.op)
                OP_RESTORE_ONE: if (addr_ok) wip_restore[rd_idx] = 1'b1;
                OP_SAVE_ONE: if (addr_ok && wp_n) begin
                    bk_save[rd_idx] = 1'b1;
                    start_busy      = 1'b1;
                end
                OP_SET_BACKUP: if (addr_ok && wp_n) begin
                    bk_set[rd_idx] = 1'b1;
                    start_busy     = 1'b1;
                end
                OP_RESTORE_ALL: begin
                    wip_restore = '1;
                    start_busy  = 1'b1;
                end
                OP_READ_BACKUP: if (addr_ok) begin
                    rd_req     = 1'b1;
                    rd_from_bk = 1'b1;
                    start_busy = 1'b1;
                end
                OP_READ_WIPER: if (addr_ok) begin
                    rd_req     = 1'b1;
                    start_busy = 1'b1;
                end
                OP_SET_WIPER: if (addr_ok && wp_n) wip_set[rd_idx] = 1'b1;
                default: ;
            endcase
        end else if (preset_go) begin
            wip_restore = '1;
            start_busy  = 1'b1;
        end
    end

endmodule

// File: rtl/wiper_bank.sv
// Module: per-channel live wiper and backup registers, both reset to midscale.
// A restore takes priority over a direct wiper write, and a save takes
// priority over a direct backup write. Assumes the decoder raises at most one
// strobe per register in any cycle.
module wiper_bank #(
    parameter int NCH = 2,
    parameter int WW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    wip_set,
    input  logic [NCH-1:0]    wip_restore,
    input  logic [NCH-1:0]    bk_save,
    input  logic [NCH-1:0]    bk_set,
    input  logic [WW-1:0]     new_val,
    output logic [NCH*WW-1:0] wiper_flat,
    output logic [NCH*WW-1:0] backup_flat
);
    localparam logic [WW-1:0] MID = {1'b1, {(WW-1){1'b0}}};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [WW-1:0] wip_q;
        logic [WW-1:0] bk_q;

        // Backup copy: capture the live wiper or a direct value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bk_q <= MID;
            end else if (bk_save[c]) begin
                bk_q <= wip_q;
            end else if (bk_set[c]) begin
                bk_q <= new_val;
            end
        end

        // Live wiper: reload from backup or take a direct value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wip_q <= MID;
            end else if (wip_restore[c]) begin
                wip_q <= bk_q;
            end else if (wip_set[c]) begin
                wip_q <= new_val;
            end
        end

        assign wiper_flat[c*WW +: WW]  = wip_q;
        assign backup_flat[c*WW +: WW] = bk_q;
    end

endmodule

// File: rtl/wiper_busy_timer.sv
// Module: busy timer. A start pulse loads BUSY_CYCLES, and the count falls by
// one each clock. Ready is high only at zero, so it stays low for exactly
// BUSY_CYCLES clocks. Assumes BUSY_CYCLES >= 1 and that start arrives only
// while ready is high.
module wiper_busy_timer #(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0] cnt;

    // Countdown: load on start, decrement to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign ready = (cnt == '0);

endmodule

// File: rtl/dual_wiper_serial_if.sv
// Module: top of the dual wiper serial interface. It joins the serial front
// end, the decoder, the register bank and the busy timer. A frame is accepted
// on the clock where cs_n rises, provided exactly FRAME_W bits were shifted
// and ready is high. Assumes every input is synchronous to clk, that
// WW <= DATA_W, and that NCH <= 15.
module dual_wiper_serial_if
    import wiper_if_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int WW          = 10,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              wp_n,
    input  logic              preset,
    output logic              sdo,
    output logic              ready,
    output logic [NCH*WW-1:0] wiper_pos
);
    localparam int CNT_W = $clog2(FRAME_W + 1) + 1;
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] frame_word;
    logic [FRAME_W-1:0] load_word;
    frame_t             frame;
    logic [CNT_W-1:0]   bit_cnt;
    logic               sclk_rise;
    logic               cs_rise;
    logic               preset_q;
    logic               preset_rise;
    logic               exec_valid;
    logic               preset_go;
    logic [NCH-1:0]     wip_set;
    logic [NCH-1:0]     wip_restore;
    logic [NCH-1:0]     bk_save;
    logic [NCH-1:0]     bk_set;
    logic               rd_req;
    logic               rd_from_bk;
    logic [IDX_W-1:0]   rd_idx;
    logic               start_busy;
    logic [NCH*WW-1:0]  wiper_flat;
    logic [NCH*WW-1:0]  backup_flat;
    logic [WW-1:0]      rd_val;

    wiper_serial_shifter #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .sdi        (sdi),
        .load_en    (rd_req),
        .load_word  (load_word),
        .frame_word (frame_word),
        .bit_cnt    (bit_cnt),
        .sclk_rise  (sclk_rise),
        .cs_rise    (cs_rise),
        .sdo        (sdo)
    );

    assign frame = frame_t'(frame_word);

    // Preset edge detector; the reset value of 1 stops a strobe held high through reset from firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preset_q <= 1'b1;
        end else begin
            preset_q <= preset;
        end
    end

    assign preset_rise = preset & ~preset_q;
    assign exec_valid  = cs_rise && (bit_cnt == FULL) && ready;
    assign preset_go   = preset_rise && ready;

    wiper_cmd_decoder #(
        .NCH   (NCH),
        .IDX_W (IDX_W)
    ) decoder_i (
        .frame       (frame),
        .exec_valid  (exec_valid),
        .preset_go   (preset_go),
        .wp_n        (wp_n),
        .wip_set     (wip_set),
        .wip_restore (wip_restore),
        .bk_save     (bk_save),
        .bk_set      (bk_set),
        .rd_req      (rd_req),
        .rd_from_bk  (rd_from_bk),
        .rd_idx      (rd_idx),
        .start_busy  (start_busy)
    );

    wiper_bank #(
        .NCH (NCH),
        .WW  (WW)
    ) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wip_set     (wip_set),
        .wip_restore (wip_restore),
        .bk_save     (bk_save),
        .bk_set      (bk_set),
        .new_val     (frame.data[WW-1:0]),
        .wiper_flat  (wiper_flat),
        .backup_flat (backup_flat)
    );

    wiper_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_busy),
        .ready (ready)
    );

    // Readback source: the addressed backup or live wiper, zero-extended to a frame.
    always_comb begin
        rd_val    = rd_from_bk ? backup_flat[rd_idx*WW +: WW] : wiper_flat[rd_idx*WW +: WW];
        load_word = {{(FRAME_W-WW){1'b0}}, rd_val};
    end

    assign wiper_pos = wiper_flat;

endmodule

// File: rtl/wiper_if_checker.sv
// Module: assertion checker bound to dual_wiper_serial_if. It watches ports
// and the signals passed between the submodules.
module wiper_if_checker #(
    parameter int NCH   = 2,
    parameter int WW    = 10,
    parameter int CNT_W = 6,
    parameter int FULL  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wp_n,
    input logic              ready,
    input logic [NCH*WW-1:0] wiper_pos,
    input logic [NCH*WW-1:0] backup_flat,
    input logic              cs_rise,
    input logic              sclk_rise,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              exec_valid,
    input logic              start_busy
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(FULL);
    localparam logic [CNT_W-1:0] SAT    = '1;

    assert_shift_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk_rise && bit_cnt != SAT) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

    assert_wp_backup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> $stable(backup_flat));

    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_busy |=> !ready);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(wiper_pos));

    assert_bad_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_cnt != FULL_C) |-> !exec_valid);

endmodule

bind dual_wiper_serial_if wiper_if_checker #(
    .NCH   (NCH),
    .WW    (WW),
    .CNT_W (CNT_W),
    .FULL  (wiper_if_pkg::FRAME_W)
) checker_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wp_n        (wp_n),
    .ready       (ready),
    .wiper_pos   (wiper_pos),
    .backup_flat (backup_flat),
    .cs_rise     (cs_rise),
    .sclk_rise   (sclk_rise),
    .bit_cnt     (bit_cnt),
    .exec_valid  (exec_valid),
    .start_busy  (start_busy)
);

// File: tb/dual_wiper_serial_if_tb_top.sv
// Bench: sweeps over wiper values, addresses, opcodes and protection states,
// with expected values kept in a small model inside the bench.
module dual_wiper_serial_if_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 150;
    localparam int WW         = 10;

    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, sdi, wp_n, preset;
    logic sdo, ready;
    logic [2*WW-1:0] wiper_pos;

    int vectors    = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [WW-1:0] exp_w [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_wiper_serial_if #(.NCH(2), .WW(WW), .BUSY_CYCLES(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .wp_n(wp_n), .preset(preset), .sdo(sdo), .ready(ready), .wiper_pos(wiper_pos)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_wipers(input string req);
        check(req, 32'(wiper_pos[WW-1:0]), 32'(exp_w[0]));
        check(req, 32'(wiper_pos[2*WW-1:WW]), 32'(exp_w[1]));
    endtask

    function automatic logic [23:0] mk(input logic [3:0] op, input logic [3:0] a, input logic [15:0] d);
        return {op, a, d};
    endfunction

    // Shift nbits of word (MSB first) and collect sdo before each rising sclk.
    task automatic xfer(input logic [23:0] word, input int nbits, output logic [23:0] got);
        got = '0;
        cs_n = 1'b0;
        tick(); tick();
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 24) ? word[23-i] : 1'b0;
            tick();
            got = {got[22:0], sdo};
            sclk = 1'b1;
            tick(); tick();
            sclk = 1'b0;
            tick();
        end
        cs_n = 1'b1;
        tick();
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready) begin
            n++;
            tick();
        end
    endtask

    // Send one full frame and check how long ready stays low.
    task automatic run(input logic [23:0] word, input int exp_busy, input string req);
        logic [23:0] g;
        int n;
        xfer(word, 24, g);
        wait_ready(n);
        check(req, 32'(n), 32'(exp_busy));
    endtask

    task automatic read_back(input logic [3:0] op, input logic [3:0] ch, input logic [WW-1:0] val, input string req);
        logic [23:0] g;
        run(mk(op, ch, 16'h0), LAT, "R9 read busy");
        xfer(mk(4'h0, 4'hF, 16'h0), 24, g);
        check(req, 32'(g), {22'b0, val});
    endtask

    task automatic pulse_preset(output int n);
        preset = 1'b1;
        tick();
        preset = 1'b0;
        wait_ready(n);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [23:0] g;
        logic [15:0] vals [6];
        int n;
        vals = '{16'h0000, 16'h0001, 16'h01FF, 16'h0200, 16'h03FF, 16'hFC05};
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; wp_n = 1'b1; preset = 1'b0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        exp_w[0] = 10'h200; exp_w[1] = 10'h200;
        check_wipers("R1 reset wiper");
        check("R1 reset ready", 32'(ready), 32'd1);
        check("R1 reset sdo", 32'(sdo), 32'd0);
        read_back(4'd9, 4'd1, 10'h200, "R1 reset backup");

        // R2 R5 R4: write sweep per channel, then read each value back.
        for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < 6; k++) begin
                run(mk(4'd11, 4'(ch), vals[k]), 0, "R9 set wiper no busy");
                exp_w[ch] = vals[k][WW-1:0];
                check_wipers("R2 R5 wiper write");
                read_back(4'd10, 4'(ch), vals[k][WW-1:0], "R4 read wiper");
            end
        end

        // R3: daisy chain returns the previous frame.
        xfer(mk(4'd0, 4'h5, 16'h5A5A), 24, g);
        xfer(mk(4'd0, 4'h6, 16'hC3C3), 24, g);
        check("R3 chain", 32'(g), 32'(mk(4'd0, 4'h5, 16'h5A5A)));

        // R5: out-of-range addresses do nothing.
        for (int a = 2; a < 16; a++) begin
            run(mk(4'd11, 4'(a), 16'h0155), 0, "R5 bad addr busy");
            check_wipers("R5 bad addr");
        end

        // R12: unused opcodes do nothing.
        for (int op = 0; op < 16; op++) begin
            if (!(op inside {1, 2, 3, 8, 9, 10, 11})) begin
                run(mk(4'(op), 4'd0, 16'h0155), 0, "R12 unused busy");
                check_wipers("R12 unused");
            end
        end

        // R6: save, set backup, restore one, restore all.
        run(mk(4'd11, 4'd0, 16'h00AA), 0, "R6 setup");
        exp_w[0] = 10'h0AA;
        run(mk(4'd2, 4'd0, 16'h0), LAT, "R9 save busy");
        read_back(4'd9, 4'd0, 10'h0AA, "R6 save");
        run(mk(4'd3, 4'd1, 16'h03C3), LAT, "R9 set backup busy");
        read_back(4'd9, 4'd1, 10'h3C3, "R6 set backup");
        check_wipers("R6 backup write leaves wiper");
        run(mk(4'd1, 4'd1, 16'h0), 0, "R9 restore one no busy");
        exp_w[1] = 10'h3C3;
        check_wipers("R6 restore one");
        run(mk(4'd11, 4'd0, 16'h0111), 0, "R6 setup");
        run(mk(4'd11, 4'd1, 16'h0222), 0, "R6 setup");
        run(mk(4'd8, 4'd0, 16'h0), LAT, "R9 restore all busy");
        exp_w[0] = 10'h0AA; exp_w[1] = 10'h3C3;
        check_wipers("R6 restore all");

        // R7: write protection.
        run(mk(4'd11, 4'd0, 16'h0123), 0, "R7 setup");
        run(mk(4'd11, 4'd1, 16'h0321), 0, "R7 setup");
        exp_w[0] = 10'h123; exp_w[1] = 10'h321;
        wp_n = 1'b0;
        run(mk(4'd11, 4'd0, 16'h0001), 0, "R7 protected set wiper");
        check_wipers("R7 protected set wiper");
        run(mk(4'd3, 4'd0, 16'h0002), 0, "R7 protected set backup");
        run(mk(4'd2, 4'd0, 16'h0), 0, "R7 protected save");
        read_back(4'd9, 4'd0, 10'h0AA, "R7 backup kept");
        run(mk(4'd1, 4'd0, 16'h0), 0, "R7 restore allowed");
        exp_w[0] = 10'h0AA;
        check_wipers("R7 restore allowed");
        pulse_preset(n);
        check("R9 preset busy", 32'(n), 32'(LAT));
        exp_w[1] = 10'h3C3;
        check_wipers("R7 R8 preset under protect");
        wp_n = 1'b1;

        // R8: preset reloads both.
        run(mk(4'd11, 4'd0, 16'h03FF), 0, "R8 setup");
        run(mk(4'd11, 4'd1, 16'h0000), 0, "R8 setup");
        pulse_preset(n);
        exp_w[0] = 10'h0AA; exp_w[1] = 10'h3C3;
        check_wipers("R8 preset");

        // R10: frames and preset ignored while busy.
        run(mk(4'd11, 4'd0, 16'h0155), 0, "R10 setup");
        run(mk(4'd11, 4'd1, 16'h0000), 0, "R10 setup");
        exp_w[0] = 10'h155; exp_w[1] = 10'h000;
        xfer(mk(4'd2, 4'd0, 16'h0), 24, g);
        check("R9 ready low after save", 32'(ready), 32'd0);
        xfer(mk(4'd11, 4'd0, 16'h0001), 24, g);
        preset = 1'b1; tick(); preset = 1'b0;
        wait_ready(n);
        check_wipers("R10 busy ignores frame and preset");
        xfer(mk(4'd8, 4'd0, 16'h0), 24, g);
        exp_w[1] = 10'h3C3;
        xfer(mk(4'd10, 4'd0, 16'h0), 24, g);
        wait_ready(n);
        xfer(mk(4'd0, 4'hF, 16'h0), 24, g);
        check("R10 busy read ignored", 32'(g), 32'(mk(4'd10, 4'd0, 16'h0)));
        check_wipers("R10 restore applied");

        // R11: wrong bit counts are discarded.
        xfer(mk(4'd11, 4'd0, 16'h02AB), 23, g);
        tick();
        check_wipers("R11 short frame");
        check("R11 short ready", 32'(ready), 32'd1);
        xfer(mk(4'd11, 4'd1, 16'h02AB), 25, g);
        tick();
        check_wipers("R11 long frame");
        check("R11 long ready", 32'(ready), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule